// File: doc/BRIEF.md
# Interrupt Presenter Register Front-End

This block is the bus-side register decoder of one per-thread interrupt presenter. A simple request bus carries a 12-bit byte address into a 4 KB window, a size code, a read/write flag and 32 bits of write data. Each request is decoded on word-index address bits [11:2]. The decoder then checks the access width against what the target register allows. The request becomes one of three things: a plain register access, a single-cycle command strobe toward the presenter core, or a faulting access.

The presenter core itself (priority arbitration, pending state) is outside the block. It appears here as two inputs: the 32-bit pending-interrupt word and the current inter-processor priority. It also appears as five outgoing strobes: poll, accept, set-current-priority, end-of-interrupt and set-inter-processor-priority. Some registers have side effects that depend on access size. A word read of the accept register acknowledges the interrupt, while a byte read of it only peeks. A byte write there sets the current priority, while a word write signals end-of-interrupt. Three 32-bit link registers are held locally.

A small state machine records how the previous request was classified. It has five states: IDLE (no request), READ (legal read), WRITE (legal write), RD_FAULT (illegal read) and WR_FAULT (illegal write). Every cycle it moves to the state named by the request sampled at that edge, and any state may move to any other. All responses are registered and appear one cycle after the request.

Top module: `ipres_regfront`

## Requirements
- R1: After reset, all strobes, rd_valid and bus_err are low, and every link register reads back as zero.
- R2: Word offset 0 (byte address 0x000) is the poll register. A word read returns core_pending. A lane-0 byte read returns core_pending[31:24] in rd_data[7:0] with the upper bits zero. Either read pulses poll_pulse. Writes to it are faults.
- R3: Word offset 1 (0x004) read as a word returns core_pending and pulses accept_pulse. Read as a lane-0 byte, it returns core_pending[31:24] in rd_data[7:0] and pulses no strobe.
- R4: A lane-0 byte write to 0x004 pulses cppr_pulse with cppr_value = req_wdata[7:0]. A word write to 0x004 pulses eoi_pulse with eoi_value = req_wdata.
- R5: Offset 0x00C allows only lane-0 byte accesses. A read returns core_ipi_prio in rd_data[7:0]. A write pulses ipi_pulse with ipi_value = req_wdata[7:0].
- R6: Offsets 0x010, 0x014 and 0x018 are three independent 32-bit link registers. They allow word access only, and a write is visible to the next read.
- R7: An access to an undecoded offset or with a disallowed size raises bus_err for one cycle. A faulting read returns 0xFFFFFFFF. A faulting write changes no register and pulses no strobe.
- R8: Size codes are 0 = byte and 2 = word. Codes 1 and 3 are always faults. A byte access is legal only when address bits [1:0] are 00.
- R9: rd_valid, bus_err and each strobe appear in the cycle after the request and last one cycle. At most one strobe fires per access.
- R10: Word accesses ignore address bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_wdata | input | 32 | Write data (byte data in bits 7:0) |
| core_pending | input | 32 | Pending-interrupt word from the core |
| core_ipi_prio | input | 8 | Current inter-processor priority |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| bus_err | output | 1 | Faulting access |
| poll_pulse | output | 1 | Poll command strobe |
| accept_pulse | output | 1 | Accept command strobe |
| cppr_pulse | output | 1 | Set current priority strobe |
| cppr_value | output | 8 | Priority carried with cppr_pulse |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| eoi_value | output | 32 | Data carried with eoi_pulse |
| ipi_pulse | output | 1 | Set inter-processor priority strobe |
| ipi_value | output | 8 | Priority carried with ipi_pulse |

## Verification
Decoding of a new request and the registered strobe or read data of the previous request share each cycle. One case is a link write immediately followed by a read of that register, whose data must already reflect the write. Another is an end-of-interrupt strobe that is still in flight while an accept read is being decoded. The bench therefore issues long runs of back-to-back random requests with no idle gaps, and changes the core inputs on every request. Each access is judged one cycle later against a reference built from the requirements, so a response that leaks into or from its neighbour shows up as a mismatch.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_POLL,
        CMD_ACCEPT,
        CMD_CPPR,
        CMD_EOI,
        CMD_IPI
    } cmd_e;

    typedef enum logic [2:0] {
        SRC_ONES,
        SRC_PEND_WORD,
        SRC_PEND_BYTE,
        SRC_IPI,
        SRC_LINK
    } rsrc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RD_FAULT,
        ST_WR_FAULT
    } state_e;

    typedef struct packed {
        logic       legal;
        cmd_e       cmd;
        rsrc_e      src;
        logic       link_we;
        logic [3:0] link_idx;
    } dec_t;

endpackage

// File: rtl/ipres_decoder.sv
module ipres_decoder
    import ipres_pkg::*;
#(
    parameter int AW        = 12,
    parameter int NUM_LINKS = 3,
    parameter int LINK_BASE = 4
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output dec_t          dec
);
    localparam int WW = AW - 2;
    localparam logic [WW-1:0] IDX_POLL   = WW'(0);
    localparam logic [WW-1:0] IDX_ACCEPT = WW'(1);
    localparam logic [WW-1:0] IDX_IPI    = WW'(3);

    logic [WW-1:0] widx;
    logic          byte0;
    logic          word;

    assign widx  = addr[AW-1:2];
    assign byte0 = (size == SZ_BYTE) && (addr[1:0] == 2'b00);
    assign word  = (size == SZ_WORD);

    always_comb begin
        dec          = '0;
        dec.cmd      = CMD_NONE;
        dec.src      = SRC_ONES;
        if (valid) begin
            if (widx == IDX_POLL) begin
                if (!write && (byte0 || word)) begin
                    dec.legal = 1'b1;
                    dec.cmd   = CMD_POLL;
                    dec.src   = word ? SRC_PEND_WORD : SRC_PEND_BYTE;
                end
            end else if (widx == IDX_ACCEPT) begin
                if (!write && word) begin
                    dec.legal = 1'b1;
                    dec.cmd   = CMD_ACCEPT;
                    dec.src   = SRC_PEND_WORD;
                end else if (!write && byte0) begin
                    dec.legal = 1'b1;
                    dec.src   = SRC_PEND_BYTE;
                end else if (write && byte0) begin
                    dec.legal = 1'b1;
                    dec.cmd   = CMD_CPPR;
                end else if (write && word) begin
                    dec.legal = 1'b1;
                    dec.cmd   = CMD_EOI;
                end
            end else if (widx == IDX_IPI) begin
                if (byte0) begin
                    dec.legal = 1'b1;
                    if (write) begin
                        dec.cmd = CMD_IPI;
                    end else begin
                        dec.src = SRC_IPI;
                    end
                end
            end else begin
                for (int i = 0; i < NUM_LINKS; i++) begin
                    if (widx == WW'(LINK_BASE + i) && word) begin
                        dec.legal    = 1'b1;
                        dec.link_idx = 4'(i);
                        if (write) begin
                            dec.link_we = 1'b1;
                        end else begin
                            dec.src = SRC_LINK;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ipres_links.sv
module ipres_links #(
    parameter int DW        = 32,
    parameter int NUM_LINKS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [3:0]    idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [NUM_LINKS*DW-1:0] flat;

    for (genvar g = 0; g < NUM_LINKS; g++) begin : gen_link
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (we && idx == 4'(g)) begin
                r <= wdata;
            end
        end
        assign flat[g*DW +: DW] = r;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (idx == 4'(i)) begin
                rdata = flat[i*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/ipres_cmd_out.sv
module ipres_cmd_out
    import ipres_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_e          cmd,
    input  logic [DW-1:0] payload,
    output logic          poll_pulse,
    output logic          accept_pulse,
    output logic          cppr_pulse,
    output logic [7:0]    cppr_value,
    output logic          eoi_pulse,
    output logic [DW-1:0] eoi_value,
    output logic          ipi_pulse,
    output logic [7:0]    ipi_value
);
    cmd_e          cmd_q;
    logic [DW-1:0] pay_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NONE;
            pay_q <= '0;
        end else begin
            cmd_q <= cmd;
            if (cmd != CMD_NONE) begin
                pay_q <= payload;
            end
        end
    end

    always_comb begin
        poll_pulse   = 1'b0;
        accept_pulse = 1'b0;
        cppr_pulse   = 1'b0;
        eoi_pulse    = 1'b0;
        ipi_pulse    = 1'b0;
        unique case (cmd_q)
            CMD_POLL:   poll_pulse   = 1'b1;
            CMD_ACCEPT: accept_pulse = 1'b1;
            CMD_CPPR:   cppr_pulse   = 1'b1;
            CMD_EOI:    eoi_pulse    = 1'b1;
            CMD_IPI:    ipi_pulse    = 1'b1;
            default:    ;
        endcase
    end

    assign cppr_value = pay_q[7:0];
    assign ipi_value  = pay_q[7:0];
    assign eoi_value  = pay_q;
endmodule

// File: rtl/ipres_regfront.sv
module ipres_regfront
    import ipres_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 32,
    parameter int NUM_LINKS = 3,
    parameter int LINK_BASE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] core_pending,
    input  logic [7:0]    core_ipi_prio,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          bus_err,
    output logic          poll_pulse,
    output logic          accept_pulse,
    output logic          cppr_pulse,
    output logic [7:0]    cppr_value,
    output logic          eoi_pulse,
    output logic [DW-1:0] eoi_value,
    output logic          ipi_pulse,
    output logic [7:0]    ipi_value
);
    localparam int PAD = DW - 8;

    dec_t          dec;
    state_e        state_q;
    state_e        state_d;
    logic [DW-1:0] link_rd;
    logic [DW-1:0] rd_next;
    logic [DW-1:0] rdata_q;

    ipres_decoder #(
        .AW(AW), .NUM_LINKS(NUM_LINKS), .LINK_BASE(LINK_BASE)
    ) i_dec (
        .valid(req_valid), .write(req_write), .addr(req_addr),
        .size(req_size), .dec(dec)
    );

    ipres_links #(.DW(DW), .NUM_LINKS(NUM_LINKS)) i_links (
        .clk(clk), .rst_n(rst_n), .we(dec.link_we), .idx(dec.link_idx),
        .wdata(req_wdata), .rdata(link_rd)
    );

    ipres_cmd_out #(.DW(DW)) i_cmd (
        .clk(clk), .rst_n(rst_n), .cmd(dec.cmd), .payload(req_wdata),
        .poll_pulse(poll_pulse), .accept_pulse(accept_pulse),
        .cppr_pulse(cppr_pulse), .cppr_value(cppr_value),
        .eoi_pulse(eoi_pulse), .eoi_value(eoi_value),
        .ipi_pulse(ipi_pulse), .ipi_value(ipi_value)
    );

    // classification of the incoming request
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (dec.legal) begin
            state_d = req_write ? ST_WRITE : ST_READ;
        end else begin
            state_d = req_write ? ST_WR_FAULT : ST_RD_FAULT;
        end
    end

    always_comb begin
        unique case (dec.src)
            SRC_PEND_WORD: rd_next = core_pending;
            SRC_PEND_BYTE: rd_next = {{PAD{1'b0}}, core_pending[DW-1 -: 8]};
            SRC_IPI:       rd_next = {{PAD{1'b0}}, core_ipi_prio};
            SRC_LINK:      rd_next = link_rd;
            default:       rd_next = '1;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid && !req_write) begin
                rdata_q <= rd_next;
            end
        end
    end

    // outputs from state
    always_comb begin
        rd_valid = 1'b0;
        bus_err  = 1'b0;
        unique case (state_q)
            ST_READ:     rd_valid = 1'b1;
            ST_RD_FAULT: begin rd_valid = 1'b1; bus_err = 1'b1; end
            ST_WR_FAULT: bus_err = 1'b1;
            default:     ;
        endcase
    end

    assign rd_data = rdata_q;
endmodule

// File: rtl/ipres_regfront_chk.sv
module ipres_regfront_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [DW-1:0] req_wdata,
    input logic [DW-1:0] core_pending,
    input logic          rd_valid,
    input logic [DW-1:0] rd_data,
    input logic          bus_err,
    input logic          poll_pulse,
    input logic          accept_pulse,
    input logic          cppr_pulse,
    input logic [7:0]    cppr_value,
    input logic          eoi_pulse,
    input logic [DW-1:0] eoi_value,
    input logic          ipi_pulse,
    input logic [7:0]    ipi_value
);
    logic [4:0] strobes;
    assign strobes = {poll_pulse, accept_pulse, cppr_pulse, eoi_pulse, ipi_pulse};

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    assert_strobe_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobes) |-> $past(req_valid));

    assert_rdvalid_follows_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    assert_fault_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (strobes == 5'b0));

    assert_fault_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && rd_valid) |-> (rd_data == '1));

    assert_accept_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_pulse |-> (rd_valid && rd_data == $past(core_pending)));

    assert_cppr_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cppr_pulse |-> (cppr_value == $past(req_wdata[7:0])));

    assert_eoi_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> (eoi_value == $past(req_wdata)));

    assert_ipi_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_pulse |-> (ipi_value == $past(req_wdata[7:0])));
endmodule

bind ipres_regfront ipres_regfront_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .core_pending(core_pending),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_err(bus_err),
    .poll_pulse(poll_pulse), .accept_pulse(accept_pulse),
    .cppr_pulse(cppr_pulse), .cppr_value(cppr_value),
    .eoi_pulse(eoi_pulse), .eoi_value(eoi_value),
    .ipi_pulse(ipi_pulse), .ipi_value(ipi_value)
);

// File: tb/test_ipres_regfront.sv
module test_ipres_regfront;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] core_pending = '0;
    logic [7:0]  core_ipi_prio = '0;
    logic        rd_valid, bus_err;
    logic [31:0] rd_data, eoi_value;
    logic        poll_pulse, accept_pulse, cppr_pulse, eoi_pulse, ipi_pulse;
    logic [7:0]  cppr_value, ipi_value;

    int checks = 0;
    int errors = 0;
    logic [31:0] link_m [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipres_regfront i_ipres_regfront (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .core_pending(core_pending), .core_ipi_prio(core_ipi_prio),
        .rd_valid(rd_valid), .rd_data(rd_data), .bus_err(bus_err),
        .poll_pulse(poll_pulse), .accept_pulse(accept_pulse),
        .cppr_pulse(cppr_pulse), .cppr_value(cppr_value),
        .eoi_pulse(eoi_pulse), .eoi_value(eoi_value),
        .ipi_pulse(ipi_pulse), .ipi_value(ipi_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input bit wr, input logic [11:0] a,
                                     input logic [1:0] sz, input bit legal);
        if (!legal) return ((sz == 2'd1 || sz == 2'd3 || (sz == 2'd0 && a[1:0] != 0))
                            ? "R8" : "R7");
        if (sz == 2'd2 && a[1:0] != 0) return "R10";
        case (a[11:2])
            10'd0: return "R2";
            10'd1: return wr ? "R4" : "R3";
            10'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // drive at a negedge, check at the following negedge
    task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd);
        logic [31:0] pend;
        logic [7:0]  ipi;
        logic [9:0]  idx;
        bit          b0, w, legal;
        logic [31:0] e_rd;
        logic [4:0]  e_str;
        int          lw;
        string       t;
        pend = $urandom();
        ipi  = 8'($urandom());
        idx  = a[11:2];
        b0   = (sz == 2'd0) && (a[1:0] == 2'b00);
        w    = (sz == 2'd2);
        legal = 0; e_rd = 32'hFFFF_FFFF; e_str = 5'b0; lw = -1;
        case (idx)
            10'd0: if (!wr && (b0 || w)) begin
                legal = 1; e_str = 5'b10000;
                e_rd = w ? pend : {24'h0, pend[31:24]};
            end
            10'd1: begin
                if (!wr && w)      begin legal = 1; e_rd = pend; e_str = 5'b01000; end
                else if (!wr && b0) begin legal = 1; e_rd = {24'h0, pend[31:24]}; end
                else if (wr && b0)  begin legal = 1; e_str = 5'b00100; end
                else if (wr && w)   begin legal = 1; e_str = 5'b00010; end
            end
            10'd3: if (b0) begin
                legal = 1;
                if (wr) e_str = 5'b00001; else e_rd = {24'h0, ipi};
            end
            10'd4, 10'd5, 10'd6: if (w) begin
                legal = 1;
                if (wr) lw = int'(idx) - 4; else e_rd = link_m[int'(idx) - 4];
            end
            default: ;
        endcase
        t = tag_of(wr, a, sz, legal);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        req_wdata = wd; core_pending = pend; core_ipi_prio = ipi;
        @(negedge clk);
        chk(rd_valid == !wr, {t, " rd_valid R9"}, 32'(rd_valid), 32'(!wr));
        if (!wr) chk(rd_data == e_rd, {t, " rd_data"}, rd_data, e_rd);
        chk(bus_err == !legal, {t, " bus_err R7"}, 32'(bus_err), 32'(!legal));
        chk({poll_pulse, accept_pulse, cppr_pulse, eoi_pulse, ipi_pulse} == e_str,
            {t, " strobes R9"},
            32'({poll_pulse, accept_pulse, cppr_pulse, eoi_pulse, ipi_pulse}), 32'(e_str));
        if (e_str[2]) chk(cppr_value == wd[7:0], {t, " cppr_value R4"},
                          32'(cppr_value), 32'(wd[7:0]));
        if (e_str[1]) chk(eoi_value == wd, {t, " eoi_value R4"}, eoi_value, wd);
        if (e_str[0]) chk(ipi_value == wd[7:0], {t, " ipi_value R5"},
                          32'(ipi_value), 32'(wd[7:0]));
        if (lw >= 0) link_m[lw] = wd;
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        chk({rd_valid, bus_err, poll_pulse, accept_pulse, cppr_pulse, eoi_pulse,
             ipi_pulse} == 7'b0, "R9 idle after request", 32'({rd_valid, bus_err,
             poll_pulse, accept_pulse, cppr_pulse, eoi_pulse, ipi_pulse}), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] a;
        logic [1:0]  sz;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) link_m[i] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        chk({rd_valid, bus_err, poll_pulse, accept_pulse, cppr_pulse, eoi_pulse,
             ipi_pulse} == 7'b0, "R1 outputs in reset", 32'({rd_valid, bus_err,
             poll_pulse, accept_pulse, cppr_pulse, eoi_pulse, ipi_pulse}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: links read zero after reset
        access(0, 12'h010, 2'd2, 0);
        access(0, 12'h014, 2'd2, 0);
        access(0, 12'h018, 2'd2, 0);
        // R2 poll
        access(0, 12'h000, 2'd2, 0);
        access(0, 12'h000, 2'd0, 0);
        access(1, 12'h000, 2'd2, 32'h1234_5678);
        // R3 accept vs peek
        access(0, 12'h004, 2'd2, 0);
        access(0, 12'h004, 2'd0, 0);
        idle_check();
        // R4 cppr and eoi, back to back
        access(1, 12'h004, 2'd0, 32'hAAAA_AA5C);
        access(1, 12'h004, 2'd2, 32'hDEAD_BEEF);
        access(0, 12'h004, 2'd2, 0);
        // R5 ipi priority
        access(0, 12'h00C, 2'd0, 0);
        access(1, 12'h00C, 2'd0, 32'h0000_00F3);
        access(1, 12'h00C, 2'd2, 32'h0000_0011);
        // R6 links, write then immediate read
        access(1, 12'h010, 2'd2, 32'h0101_0101);
        access(1, 12'h014, 2'd2, 32'h0202_0202);
        access(1, 12'h018, 2'd2, 32'h0303_0303);
        access(0, 12'h010, 2'd2, 0);
        access(0, 12'h014, 2'd2, 0);
        access(0, 12'h018, 2'd2, 0);
        // R7 faults: unmapped, write ignored, byte on link ignored
        access(1, 12'h008, 2'd2, 32'hFFFF_0000);
        access(0, 12'h800, 2'd2, 0);
        access(1, 12'h010, 2'd0, 32'h0000_00EE);
        access(0, 12'h010, 2'd2, 0);
        // R8 lane and size rules
        access(0, 12'h001, 2'd0, 0);
        access(1, 12'h005, 2'd0, 32'h77);
        access(0, 12'h004, 2'd1, 0);
        access(1, 12'h004, 2'd3, 32'h99);
        access(0, 12'h00F, 2'd0, 0);
        // R10 word ignores low address bits
        access(1, 12'h017, 2'd2, 32'hCAFE_F00D);
        access(0, 12'h015, 2'd2, 0);
        access(0, 12'h007, 2'd2, 0);
        idle_check();
        // random back-to-back traffic
        for (int i = 0; i < 1500; i++) begin
            a = {5'($urandom_range(0, 1) ? 5'd0 : 5'($urandom())),
                 5'($urandom_range(0, 7)), 2'b00};
            if ($urandom_range(0, 7) == 0) a[1:0] = 2'($urandom());
            sz = ($urandom_range(0, 3) != 0) ? ($urandom_range(0, 1) ? 2'd2 : 2'd0)
                                             : 2'($urandom());
            access(1'($urandom()), a, sz, $urandom());
            if ($urandom_range(0, 15) == 0) idle_check();
        end
        idle_check();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule